// File: doc/BRIEF.md
# Hash Unit Register Front-End

This block sits between a host register bus and a message-digest core. It decodes word addresses into four kinds of target: a mode register, a small control/status group, a bank of 64-bit key registers, and a wide FIFO window. Any write that lands anywhere in the FIFO window pushes the 64-bit write data into a private input queue. Any read from that window returns zero and leaves the queue untouched. The hash core drains the queue in arrival order through a valid/ready pop port.

The mode register holds a two-bit algorithm select. When the select names MD5, the block byte-reverses key data inside each 32-bit half. This happens on the way into the key registers and again on the way out to the bus. The key registers therefore always hold the big-endian form that the core reads from `key_o`.

The block checks mode writes for errors. A write that sets a reserved bit raises a data error. A write made while the core reports busy raises a context error, and that write is discarded. An overflowing push raises a third error. All three error flags are sticky. They clear through a write-one-to-clear register or through a re-initialize command. The bus read path is combinational, and every write takes effect at the next clock edge.

Top module: `hash_reg_frontend`

## Requirements
- R1: After reset, the mode reads 0, the status reads 0, `pop_valid_o` is 0 and `key_o` is all zero. The status word has data error at bit 0, context error at bit 1, overflow at bit 2, and queue occupancy at bits 12:8.
- R2: A write to any word address from 0x40 to 0x7F pushes `bus_wdata` into the input queue. The pop port presents the entries in push order, and an entry leaves when `pop_valid_o` and `pop_ready_i` are both high at a clock edge.
- R3: The queue holds 16 entries. A push while 16 entries are held is dropped, the occupancy stays at 16, and the overflow flag (status bit 2) is set.
- R4: A read from any address from 0x40 to 0x7F returns zero and does not change the queue occupancy.
- R5: The mode register is at address 0x00. Its bits 1:0 select the algorithm: 00 SHA-1, 01 SHA-224, 10 SHA-256, 11 MD5. The stored select reads back on bits 1:0 and drives `mode_algo_o`.
- R6: A key write to address 0x08+k (k = 0..3) stores the data unchanged under the three SHA selects. Under MD5 it stores the data with the bytes reversed inside each 32-bit half. Word k appears on `key_o[64k+63:64k]`.
- R7: A key read returns the stored word under the SHA selects and the half-wise byte-reversed stored word under MD5.
- R8: A mode write with any of bits 7:2 set sets the data-error flag (status bit 0). The reserved bits are not stored, and bits 1:0 are still taken.
- R9: A mode write while `busy_i` is high sets the context-error flag (status bit 1) and leaves the stored mode unchanged.
- R10: The error flags stay set until a write to address 0x02 has a 1 in the matching bit position (bit 0, 1 or 2). A 0 in a position leaves that flag alone.
- R11: Any write to address 0x03 clears the mode, all error flags and the input queue.
- R12: Reads from addresses outside the mode, status, key and FIFO ranges return zero. Writes to those addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, combinational from address |
| busy_i | input | 1 | Hash core is processing |
| pop_valid_o | output | 1 | Queue head is valid |
| pop_ready_i | input | 1 | Core accepts the queue head |
| pop_data_o | output | 64 | Queue head data |
| mode_algo_o | output | 2 | Stored algorithm select |
| key_o | output | 256 | Key words in big-endian form |

## Verification
The bench writes to every one of the 64 window addresses and reads from every one while the queue is full. A decoder that narrowed the window, or a read that popped, would show as lost or missing entries or a shrinking occupancy. It pushes a seventeenth word into a full queue and checks that the word is dropped and the overflow flag raised. A queue that wrapped over its head would return the wrong order on drain.

For each of the four selects it writes every key word and compares `key_o` with a byte permutation computed in the bench. It also switches to MD5 after a SHA-mode write to catch a read path that forgets to reverse. It walks each reserved mode bit and issues a mode write under busy. It then clears one flag at a time, which catches clears that wipe all flags and modes that change despite the busy signal.

// File: rtl/hfe_pkg.sv
// Package: shared constants, types and helpers of the hash unit front-end.
// Assumes a 64-bit data bus and word addressing.
package hfe_pkg;

    localparam int DATA_W    = 64;
    localparam int MODE_W    = 8;
    localparam int ALGO_W    = 2;
    localparam int FLAG_W    = 3;
    localparam int MODE_ADDR = 0;
    localparam int STAT_ADDR = 1;
    localparam int CLR_ADDR  = 2;
    localparam int INIT_ADDR = 3;
    localparam int KEY_BASE  = 8;
    localparam int CNT_LSB   = 8;

    // Flag bit positions inside the status word
    localparam int F_DATA = 0;
    localparam int F_CTX  = 1;
    localparam int F_OVF  = 2;

    typedef enum logic [ALGO_W-1:0] {
        ALGO_SHA1   = 2'b00,
        ALGO_SHA224 = 2'b01,
        ALGO_SHA256 = 2'b10,
        ALGO_MD5    = 2'b11
    } algo_e;

    typedef struct packed {
        logic mode;
        logic stat;
        logic clr;
        logic init;
        logic key;
        logic fifo;
    } hit_t;

    // Reverse the byte order inside each 32-bit half of a 64-bit word.
    function automatic logic [DATA_W-1:0] swap_halves(input logic [DATA_W-1:0] d);
        return {d[39:32], d[47:40], d[55:48], d[63:56],
                d[7:0],   d[15:8],  d[23:16], d[31:24]};
    endfunction

endpackage

// File: rtl/hfe_addr_dec.sv
// Address decoder: turns a word address into one hit per target range.
// Assumes KEY_WORDS is a power of two and KEY_BASE is aligned to it.
module hfe_addr_dec
    import hfe_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int KEY_WORDS = 4,
    parameter int FIFO_BASE = 64,
    parameter int FIFO_SPAN = 64,
    localparam int KIDX_W   = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit,
    output logic [KIDX_W-1:0] key_idx
);

    localparam logic [ADDR_W-1:0] FIFO_LO = ADDR_W'(FIFO_BASE);
    localparam logic [ADDR_W-1:0] FIFO_HI = ADDR_W'(FIFO_BASE + FIFO_SPAN - 1);
    localparam logic [ADDR_W-KIDX_W-1:0] KEY_TAG = (ADDR_W-KIDX_W)'(KEY_BASE >> KIDX_W);

    // Compare the address against every target range
    always_comb begin
        hit      = '0;
        hit.mode = (addr == ADDR_W'(MODE_ADDR));
        hit.stat = (addr == ADDR_W'(STAT_ADDR));
        hit.clr  = (addr == ADDR_W'(CLR_ADDR));
        hit.init = (addr == ADDR_W'(INIT_ADDR));
        hit.key  = (addr[ADDR_W-1:KIDX_W] == KEY_TAG);
        hit.fifo = (addr >= FIFO_LO) && (addr <= FIFO_HI);
        key_idx  = addr[KIDX_W-1:0];
    end

endmodule

// File: rtl/hfe_ctrl.sv
// Mode and error-flag control: holds the algorithm select and three sticky
// error flags. Assumes at most one bus write per cycle.
module hfe_ctrl
    import hfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reinit,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              busy_i,
    input  logic              clr_wr,
    input  logic [FLAG_W-1:0] clr_mask,
    input  logic              ovf_evt,
    output logic [ALGO_W-1:0] algo,
    output logic [FLAG_W-1:0] flags
);

    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] flags_nx;

    // Gather error events; a new event wins over a clear in the same cycle
    always_comb begin
        set_vec         = '0;
        set_vec[F_DATA] = mode_wr && (|mode_wdata[MODE_W-1:ALGO_W]);
        set_vec[F_CTX]  = mode_wr && busy_i;
        set_vec[F_OVF]  = ovf_evt;
        flags_nx        = (flags & ~(clr_wr ? clr_mask : '0)) | set_vec;
    end

    // Register the mode and flags, with reset and re-initialize clearing both
    always_ff @(posedge clk) begin
        if (!rst_n || reinit) begin
            algo  <= '0;
            flags <= '0;
        end else begin
            flags <= flags_nx;
            if (mode_wr && !busy_i) begin
                algo <= mode_wdata[ALGO_W-1:0];
            end
        end
    end

endmodule

// File: rtl/hfe_key_bank.sv
// Key register bank: stores key words in big-endian form, byte-reversing
// each 32-bit half on write and read when the little-endian hash is chosen.
module hfe_key_bank
    import hfe_pkg::*;
#(
    parameter int KEY_WORDS = 4,
    localparam int KIDX_W   = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [KIDX_W-1:0]           idx,
    input  logic [DATA_W-1:0]           wdata,
    input  logic                        little_end,
    output logic [DATA_W-1:0]           rdata,
    output logic [KEY_WORDS*DATA_W-1:0] key_flat
);

    logic [DATA_W-1:0] words [KEY_WORDS];
    logic [DATA_W-1:0] wr_form;

    // Convert bus data into stored form
    always_comb wr_form = little_end ? swap_halves(wdata) : wdata;

    for (genvar g = 0; g < KEY_WORDS; g++) begin : g_word
        // Hold one key word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (wr && (idx == KIDX_W'(g))) begin
                words[g] <= wr_form;
            end
        end
        assign key_flat[g*DATA_W +: DATA_W] = words[g];
    end

    // Convert stored form back to bus order
    always_comb rdata = little_end ? swap_halves(words[idx]) : words[idx];

endmodule

// File: rtl/hfe_in_fifo.sv
// Input queue: in-order storage with a push port and a valid/ready pop port.
// A push while full is dropped. Assumes DEPTH is a power of two.
module hfe_in_fifo
    import hfe_pkg::*;
#(
    parameter int DEPTH   = 16,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_ready,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              full
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  rptr;
    logic              do_push;
    logic              do_pop;

    // Qualify the push and pop requests
    always_comb begin
        full      = (count == CNT_W'(DEPTH));
        pop_valid = (count != '0);
        do_push   = push && !full;
        do_pop    = pop_valid && pop_ready;
        pop_data  = mem[rptr];
    end

    // Write the storage array
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= push_data;
        end
    end

    // Advance the pointers and the occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + PTR_W'(1);
            if (do_pop)  rptr <= rptr + PTR_W'(1);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

endmodule

// File: rtl/hash_reg_frontend.sv
// Top: register and FIFO front-end of a message-digest unit. It decodes the
// bus, routes writes, and muxes combinational read data.
// Assumes one access per cycle and KEY_BASE..KEY_BASE+KEY_WORDS-1 below
// the FIFO window.
module hash_reg_frontend
    import hfe_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int KEY_WORDS  = 4,
    parameter int FIFO_DEPTH = 16,
    parameter int FIFO_BASE  = 64,
    parameter int FIFO_SPAN  = 64,
    localparam int KIDX_W    = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_req,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic                        busy_i,
    output logic                        pop_valid_o,
    input  logic                        pop_ready_i,
    output logic [DATA_W-1:0]           pop_data_o,
    output logic [ALGO_W-1:0]           mode_algo_o,
    output logic [KEY_WORDS*DATA_W-1:0] key_o
);

    hit_t              hit;
    logic [KIDX_W-1:0] key_idx;
    logic              wr_en;
    logic              rd_en;
    logic              mode_wr;
    logic              clr_wr;
    logic              init_wr;
    logic              key_wr;
    logic              fifo_push;
    logic              fifo_rd;
    logic              fifo_full;
    logic              pop_fire;
    logic [CNT_W-1:0]  fifo_count;
    logic [FLAG_W-1:0] err_flags;
    logic [DATA_W-1:0] key_rdata;
    logic              is_md5;

    hfe_addr_dec #(
        .ADDR_W    (ADDR_W),
        .KEY_WORDS (KEY_WORDS),
        .FIFO_BASE (FIFO_BASE),
        .FIFO_SPAN (FIFO_SPAN)
    ) u_dec (
        .addr    (bus_addr),
        .hit     (hit),
        .key_idx (key_idx)
    );

    // Qualify bus strobes per target
    always_comb begin
        wr_en     = bus_req && bus_we;
        rd_en     = bus_req && !bus_we;
        mode_wr   = wr_en && hit.mode;
        clr_wr    = wr_en && hit.clr;
        init_wr   = wr_en && hit.init;
        key_wr    = wr_en && hit.key;
        fifo_push = wr_en && hit.fifo;
        fifo_rd   = rd_en && hit.fifo;
        pop_fire  = pop_valid_o && pop_ready_i;
        is_md5    = (mode_algo_o == ALGO_MD5);
    end

    hfe_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reinit     (init_wr),
        .mode_wr    (mode_wr),
        .mode_wdata (bus_wdata[MODE_W-1:0]),
        .busy_i     (busy_i),
        .clr_wr     (clr_wr),
        .clr_mask   (bus_wdata[FLAG_W-1:0]),
        .ovf_evt    (fifo_push && fifo_full),
        .algo       (mode_algo_o),
        .flags      (err_flags)
    );

    hfe_key_bank #(
        .KEY_WORDS (KEY_WORDS)
    ) u_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (key_wr),
        .idx        (key_idx),
        .wdata      (bus_wdata),
        .little_end (is_md5),
        .rdata      (key_rdata),
        .key_flat   (key_o)
    );

    hfe_in_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (init_wr),
        .push      (fifo_push),
        .push_data (bus_wdata),
        .pop_ready (pop_ready_i),
        .pop_valid (pop_valid_o),
        .pop_data  (pop_data_o),
        .count     (fifo_count),
        .full      (fifo_full)
    );

    // Select read data; FIFO window and unmapped space read as zero
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            if (hit.mode)     bus_rdata = DATA_W'(mode_algo_o);
            else if (hit.stat) bus_rdata = (DATA_W'(fifo_count) << CNT_LSB) | DATA_W'(err_flags);
            else if (hit.key) bus_rdata = key_rdata;
        end
    end

endmodule

// File: rtl/hfe_checker.sv
// Checker: temporal properties of the front-end, bound into the top module.
module hfe_checker
    import hfe_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_req,
    input logic              fifo_rd,
    input logic              pop_fire,
    input logic [CNT_W-1:0]  count,
    input logic              mode_wr,
    input logic              busy_i,
    input logic [ALGO_W-1:0] algo,
    input logic [FLAG_W-1:0] flags,
    input logic              reinit
);

    // R3: occupancy never exceeds the depth
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(FIFO_DEPTH));

    // R3: a push into a full queue is dropped and flags overflow
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_fire && !reinit && count == CNT_W'(FIFO_DEPTH))
        |=> (count == CNT_W'(FIFO_DEPTH)) && flags[F_OVF]);

    // R4: a window read without a pop leaves the occupancy alone
    assert_read_no_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && !pop_fire) |=> count == $past(count));

    // R9: a mode write under busy keeps the mode and raises a context error
    assert_busy_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && busy_i) |=> $stable(algo) && flags[F_CTX]);

    // R11: re-initialize empties queue, mode and flags
    assert_reinit_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> (count == '0) && (algo == '0) && (flags == '0));

endmodule

bind hash_reg_frontend hfe_checker #(
    .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (fifo_push),
    .fifo_rd  (fifo_rd),
    .pop_fire (pop_fire),
    .count    (fifo_count),
    .mode_wr  (mode_wr),
    .busy_i   (busy_i),
    .algo     (mode_algo_o),
    .flags    (err_flags),
    .reinit   (init_wr)
);

// File: tb/hash_reg_frontend_bench.sv
module hash_reg_frontend_bench;

    localparam int AW = 8;
    localparam int KW = 4;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [63:0]   bus_wdata = '0;
    logic [63:0]   bus_rdata;
    logic          busy_i = 1'b0;
    logic          pop_valid_o;
    logic          pop_ready_i = 1'b0;
    logic [63:0]   pop_data_o;
    logic [1:0]    mode_algo_o;
    logic [KW*64-1:0] key_o;

    int n_tests = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    hash_reg_frontend u_hash_reg_frontend (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .busy_i      (busy_i),
        .pop_valid_o (pop_valid_o),
        .pop_ready_i (pop_ready_i),
        .pop_data_o  (pop_data_o),
        .mode_algo_o (mode_algo_o),
        .key_o       (key_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [AW-1:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bread(input logic [AW-1:0] a, output logic [63:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic pop_check(input string tag, input logic [63:0] exp);
        @(negedge clk);
        check({tag, " valid"}, 64'(pop_valid_o), 64'd1);
        check({tag, " data"}, pop_data_o, exp);
        pop_ready_i = 1'b1;
        @(negedge clk);
        pop_ready_i = 1'b0;
    endtask

    // Expected reversal: byte b moves to position 4*(b/4) + 3 - b%4
    function automatic logic [63:0] exp_swap(input logic [63:0] d);
        logic [63:0] r = '0;
        for (int b = 0; b < 8; b++) begin
            r[((b / 4) * 4 + 3 - (b % 4)) * 8 +: 8] = d[b * 8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [63:0] stat_exp(input int cnt, input int fl);
        return (64'(cnt) << 8) | 64'(fl);
    endfunction

    function automatic logic [63:0] fifo_word(input int c, input int i);
        return 64'h0123_4567_89AB_CDEF ^ (64'(c) << 48) ^ (64'(i) * 64'h0000_0101_0001_0011);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] rd;
        logic [63:0] kd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bread(8'h00, rd); check("R1 mode", rd, 64'd0);
        bread(8'h01, rd); check("R1 status", rd, 64'd0);
        check("R1 pop_valid", 64'(pop_valid_o), 64'd0);
        check("R1 key", 64'(|key_o), 64'd0);

        // R5: every algorithm select
        for (int a = 0; a < 4; a++) begin
            bwrite(8'h00, 64'(a));
            check("R5 mode_algo_o", 64'(mode_algo_o), 64'(a));
            bread(8'h00, rd); check("R5 mode read", rd, 64'(a));
        end

        // R6 / R7: key store and readback under each select
        for (int a = 0; a < 4; a++) begin
            bwrite(8'h00, 64'(a));
            for (int k = 0; k < KW; k++) begin
                kd = 64'h1122_3344_5566_7788 + (64'(a) << 60) + (64'(k) << 32) + 64'(k * 7);
                bwrite(8'(8 + k), kd);
                check("R6 key_o", key_o[k*64 +: 64], (a == 3) ? exp_swap(kd) : kd);
                bread(8'(8 + k), rd); check("R7 key read", rd, kd);
            end
        end
        // R7: SHA-written key read back under MD5
        bwrite(8'h00, 64'd2);
        kd = 64'hA1B2_C3D4_E5F6_0718;
        bwrite(8'h09, kd);
        bwrite(8'h00, 64'd3);
        bread(8'h09, rd); check("R7 md5 view", rd, exp_swap(kd));

        // R8: each reserved bit sets data error, algo still taken
        for (int b = 2; b < 8; b++) begin
            bwrite(8'h00, (64'd1 << b) | 64'd1);
            bread(8'h01, rd); check("R8 data err", rd, stat_exp(0, 1));
            bread(8'h00, rd); check("R8 mode stored", rd, 64'd1);
            bwrite(8'h02, 64'd1);
            bread(8'h01, rd); check("R10 clear data", rd, 64'd0);
        end

        // R9: mode write under busy
        busy_i = 1'b1;
        bwrite(8'h00, 64'd3);
        busy_i = 1'b0;
        bread(8'h01, rd); check("R9 ctx err", rd, stat_exp(0, 2));
        bread(8'h00, rd); check("R9 mode kept", rd, 64'd1);
        // R10: clearing another bit leaves the flag set
        bwrite(8'h02, 64'd5);
        bread(8'h01, rd); check("R10 sticky", rd, stat_exp(0, 2));
        bwrite(8'h02, 64'd2);
        bread(8'h01, rd); check("R10 clear ctx", rd, 64'd0);

        // R2 / R3 / R4: sweep the whole window in four chunks
        for (int c = 0; c < 4; c++) begin
            for (int i = 0; i < DEPTH; i++) begin
                bwrite(8'(64 + c * 16 + i), fifo_word(c, i));
            end
            bread(8'h01, rd); check("R2 count full", rd, stat_exp(16, 0));
            if (c == 0) begin
                bwrite(8'h7F, 64'hDEAD_BEEF_DEAD_BEEF);
                bread(8'h01, rd); check("R3 overflow", rd, stat_exp(16, 4));
                bwrite(8'h02, 64'd4);
            end
            for (int i = 0; i < 16; i++) begin
                bread(8'(64 + c * 16 + i), rd); check("R4 window read", rd, 64'd0);
            end
            bread(8'h01, rd); check("R4 count kept", rd, stat_exp(16, 0));
            for (int i = 0; i < DEPTH; i++) begin
                pop_check("R2 order", fifo_word(c, i));
            end
            @(negedge clk);
            check("R2 drained", 64'(pop_valid_o), 64'd0);
        end

        // R11: re-initialize
        bwrite(8'h00, 64'd3);
        bwrite(8'h40, 64'd1); bwrite(8'h55, 64'd2); bwrite(8'h6A, 64'd3);
        bwrite(8'h00, 64'h83);
        bread(8'h01, rd); check("R11 pre", rd, stat_exp(3, 1));
        bwrite(8'h03, 64'd0);
        bread(8'h01, rd); check("R11 status", rd, 64'd0);
        bread(8'h00, rd); check("R11 mode", rd, 64'd0);
        check("R11 pop_valid", 64'(pop_valid_o), 64'd0);

        // R12: unmapped space
        for (int a = 0; a < 256; a++) begin
            if (!(a < 4 || (a >= 8 && a < 12) || (a >= 64 && a < 128))) begin
                bwrite(8'(a), 64'hFFFF_FFFF_FFFF_FFFF);
                bread(8'(a), rd); check("R12 unmapped read", rd, 64'd0);
            end
        end
        bread(8'h01, rd); check("R12 status kept", rd, 64'd0);
        bread(8'h00, rd); check("R12 mode kept", rd, 64'd0);
        check("R12 key kept", key_o[64 +: 64], kd);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule